// File: doc/BRIEF.md
# Load/Store Lane Steering and Extension Unit

This unit sits between a 32-bit processor core and a byte-addressed data memory that is one word wide. The core presents an address, an access size, a signed/unsigned flag, a load/store select and the store data. The unit returns three things. The first is the per-byte write enables for the memory. The second is the store data copied onto every byte lane it could occupy. The third is the load result, taken from the memory's read word and then sign-extended or zero-extended to the full word.

The unit also checks alignment. A word access must fall on an address that is a multiple of four. A halfword access must fall on an even address. When an access breaks either rule, the unit raises a flag for the exception logic, drops every write enable and returns zero as the load result. A static parameter fixes the byte order, and that choice decides which byte lane holds the byte at each address offset. All paths are combinational, so a load result is ready in the same cycle as the read word.

Top module: `ls_align`

## Requirements
- R1: Size code 2'b10 is a word and 2'b11 is treated as a word too. A word access with address bits [1:0] not equal to 0 raises `misaligned`. A word access at offset 0 does not raise it.
- R2: Size code 2'b01 is a halfword. A halfword access with address bit 0 set raises `misaligned`. Size code 2'b00 is a byte, and a byte access never raises it.
- R3: While `misaligned` is high, `byte_en` is 4'b0000 and `load_data` is zero.
- R4: For an aligned store (`is_store`=1), `byte_en` sets exactly the lanes the access covers: one lane for a byte, two for a halfword, all four for a word. For a load (`is_store`=0), `byte_en` is 4'b0000.
- R5: `store_lanes` repeats the byte `store_data[7:0]` in all four lanes for a byte access. It repeats `store_data[15:0]` in both halves for a halfword. For a word it equals `store_data`.
- R6: A signed (`is_signed`=1) byte or halfword load copies the selected value's top bit into every higher bit of `load_data`. A word load returns the selected word unchanged.
- R7: An unsigned (`is_signed`=0) byte or halfword load fills every bit above the selected value with zero.
- R8: Lane `k` is `mem_rdata[8k+7:8k]` and enable bit `k`. With `BIG_ENDIAN`=0, the byte at offset `o` uses lane `o`, and a halfword at offset `o` uses lanes `o+1:o`. With `BIG_ENDIAN`=1, the byte at offset `o` uses lane `3-o`, and a halfword at offset `o` uses lanes `3-o:2-o`. In both modes a halfword's more significant byte lies in the higher lane.
- R9: All outputs follow the inputs in the same cycle with no register in the path. Address bits above bit 1 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| is_signed | input | 1 | 1: sign-extend a partial load; 0: zero-extend |
| is_store | input | 1 | 1: store; 0: load |
| store_data | input | DATA_W | Store value, right-justified |
| mem_rdata | input | DATA_W | Word returned by the data memory |
| byte_en | output | DATA_W/8 | Per-lane write enables to memory |
| store_lanes | output | DATA_W | Store value copied onto the byte lanes |
| load_data | output | DATA_W | Extended load result |
| misaligned | output | 1 | Access breaks the alignment rule for its size |

## Verification
Every output is combinational, so each result is due in the cycle that its stimulus is applied, with zero clock latency. The bench changes the inputs just after a rising edge. It reads all four outputs at the next falling edge, which lies inside the same clock period, so no check waits for a later edge. One directed test changes only the low address bits within a single period and samples twice before the next rising edge. This shows that nothing is held across a clock.

// File: rtl/ls_align_pkg.sv
`timescale 1ns/1ps
// Shared types for the load/store lane steering unit.
// Assumes a two-bit size code; the fourth code behaves as a word.
package ls_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    // True when the size code selects a full word.
    function automatic logic is_word(input logic [1:0] sz);
        return sz[1];
    endfunction

endpackage

// File: rtl/ls_align_check.sv
`timescale 1ns/1ps
// Alignment checker: flags word accesses off a word boundary and
// halfword accesses on odd addresses. Byte accesses are always legal.
// Assumes LANES is a power of two and at least 4.
module ls_align_check
    import ls_align_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    output logic             misaligned
);

    // Decide legality from the low offset bits and the size code.
    always_comb begin
        misaligned = 1'b0;
        if (is_word(size))
            misaligned = (offset != '0);
        else if (size == SZ_HALF)
            misaligned = offset[0];
    end

endmodule

// File: rtl/ls_store_steer.sv
`timescale 1ns/1ps
// Store lane steering: builds the per-lane write enables and copies the
// store value across every lane it could occupy. Enables are only raised
// for aligned stores. Lane order follows BIG_ENDIAN.
module ls_store_steer
    import ls_align_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0,
    localparam int LANES  = DATA_W / 8,
    localparam int HALVES = LANES / 2,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        size,
    input  logic              is_store,
    input  logic              misaligned,
    input  logic [DATA_W-1:0] store_data,
    output logic [LANES-1:0]  byte_en,
    output logic [DATA_W-1:0] store_lanes
);

    logic [OFF_W-1:0] byte_lane;
    logic [OFF_W-2:0] half_slot;
    logic             wr_ok;

    // Map the address offset onto the physical byte lane and halfword slot.
    always_comb begin
        if (BIG_ENDIAN) begin
            byte_lane = OFF_W'(LANES - 1) - offset;
            half_slot = (OFF_W-1)'(HALVES - 1) - offset[OFF_W-1:1];
        end else begin
            byte_lane = offset;
            half_slot = offset[OFF_W-1:1];
        end
    end

    // A write is allowed only for an aligned store.
    assign wr_ok = is_store && !misaligned;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Enable one lane when the access covers it.
        always_comb begin
            if (!wr_ok)
                byte_en[l] = 1'b0;
            else if (is_word(size))
                byte_en[l] = 1'b1;
            else if (size == SZ_HALF)
                byte_en[l] = ((l / 2) == int'(half_slot));
            else
                byte_en[l] = (OFF_W'(l) == byte_lane);
        end

        // Place the matching slice of the store value on this lane.
        always_comb begin
            if (is_word(size))
                store_lanes[8*l +: 8] = store_data[8*l +: 8];
            else if (size == SZ_HALF)
                store_lanes[8*l +: 8] = store_data[8*(l % 2) +: 8];
            else
                store_lanes[8*l +: 8] = store_data[7:0];
        end
    end

endmodule

// File: rtl/ls_load_extract.sv
`timescale 1ns/1ps
// Load extraction: picks the addressed byte or halfword from the memory
// word, then sign- or zero-extends it. A misaligned access returns zero.
// Purely combinational; lane order follows BIG_ENDIAN.
module ls_load_extract
    import ls_align_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0,
    localparam int LANES  = DATA_W / 8,
    localparam int HALVES = LANES / 2,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        size,
    input  logic              is_signed,
    input  logic              misaligned,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] load_data
);

    logic [OFF_W-1:0] byte_lane;
    logic [OFF_W-2:0] half_slot;
    logic [7:0]       lanes  [LANES];
    logic [15:0]      halves [HALVES];
    logic [7:0]       sel_byte;
    logic [15:0]      sel_half;

    // Map the address offset onto the physical byte lane and halfword slot.
    always_comb begin
        if (BIG_ENDIAN) begin
            byte_lane = OFF_W'(LANES - 1) - offset;
            half_slot = (OFF_W-1)'(HALVES - 1) - offset[OFF_W-1:1];
        end else begin
            byte_lane = offset;
            half_slot = offset[OFF_W-1:1];
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lanes[l] = mem_rdata[8*l +: 8];
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign halves[h] = mem_rdata[16*h +: 16];
    end

    // Select the addressed byte and halfword.
    always_comb begin
        sel_byte = lanes[byte_lane];
        sel_half = halves[half_slot];
    end

    // Extend the selected value to the full width.
    always_comb begin
        if (misaligned)
            load_data = '0;
        else if (is_word(size))
            load_data = mem_rdata;
        else if (size == SZ_HALF)
            load_data = {{(DATA_W-16){is_signed & sel_half[15]}}, sel_half};
        else
            load_data = {{(DATA_W-8){is_signed & sel_byte[7]}}, sel_byte};
    end

endmodule

// File: rtl/ls_align.sv
`timescale 1ns/1ps
// Load/store lane steering and extension unit (top).
// Sits between the core and a one-word-wide byte-addressed memory.
// Assumes DATA_W is a multiple of 16 with a power-of-two lane count.
// No state is held: every output follows the inputs in the same cycle.
module ls_align
    import ls_align_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              is_signed,
    input  logic              is_store,
    input  logic [DATA_W-1:0] store_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [LANES-1:0]  byte_en,
    output logic [DATA_W-1:0] store_lanes,
    output logic [DATA_W-1:0] load_data,
    output logic              misaligned
);

    logic [OFF_W-1:0] offset;
    logic             unused_addr_hi;

    // Only the offset inside the word steers the lanes.
    assign offset         = addr[OFF_W-1:0];
    assign unused_addr_hi = ^addr[ADDR_W-1:OFF_W];

    ls_align_check #(
        .LANES (LANES)
    ) u_check (
        .offset     (offset),
        .size       (size),
        .misaligned (misaligned)
    );

    ls_store_steer #(
        .DATA_W     (DATA_W),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_store (
        .offset      (offset),
        .size        (size),
        .is_store    (is_store),
        .misaligned  (misaligned),
        .store_data  (store_data),
        .byte_en     (byte_en),
        .store_lanes (store_lanes)
    );

    ls_load_extract #(
        .DATA_W     (DATA_W),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_load (
        .offset     (offset),
        .size       (size),
        .is_signed  (is_signed),
        .misaligned (misaligned),
        .mem_rdata  (mem_rdata),
        .load_data  (load_data)
    );

endmodule

// File: rtl/ls_align_sva.sv
`timescale 1ns/1ps
// Checker for ls_align: relates the alignment flag, enables, copied store
// lanes and the load result. Uses immediate checks because the unit has
// no clock.
module ls_align_sva #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        size,
    input logic              is_signed,
    input logic              is_store,
    input logic [LANES-1:0]  byte_en,
    input logic [DATA_W-1:0] store_lanes,
    input logic [DATA_W-1:0] load_data,
    input logic              misaligned
);

    logic unused_sva_addr;
    assign unused_sva_addr = ^addr[ADDR_W-1:2];

    // Check each output rule whenever the inputs change.
    always_comb begin
        a_r1_word_flag: assert (!(size[1] && addr[1:0] != 2'b00) || misaligned);
        a_r2_half_flag: assert (!(size == 2'b01 && addr[0]) || misaligned);
        a_r2_byte_ok:   assert (!(size == 2'b00) || !misaligned);
        a_r3_no_write:  assert (!misaligned || byte_en == '0);
        a_r3_zero_load: assert (!misaligned || load_data == '0);
        a_r4_load_no_en: assert (is_store || byte_en == '0);
        a_r4_en_count:  assert (!(is_store && !misaligned) ||
                                ($countones(byte_en) ==
                                 (size[1] ? LANES : (size[0] ? 2 : 1))));
        a_r5_byte_copy: assert (!(size == 2'b00) ||
                                store_lanes[DATA_W-1 -: 8] == store_lanes[7:0]);
        a_r6_sign_byte: assert (!(size == 2'b00 && is_signed) ||
                                load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}});
        a_r7_zero_half: assert (!(size == 2'b01 && !is_signed) ||
                                load_data[DATA_W-1:16] == '0);
    end

endmodule

bind ls_align ls_align_sva #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_sva (
    .addr        (addr),
    .size        (size),
    .is_signed   (is_signed),
    .is_store    (is_store),
    .byte_en     (byte_en),
    .store_lanes (store_lanes),
    .load_data   (load_data),
    .misaligned  (misaligned)
);

// File: tb/ls_align_bench.sv
`timescale 1ns/1ps
module ls_align_bench;

    localparam logic [31:0] WDATA = 32'h1234_A5B6;
    localparam logic [31:0] RDATA = 32'h8C7A_F312;
    localparam int NVEC = 17;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        sgn;
        logic        st;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] ld;
        logic        mis;
    } vec_t;

    // Little-endian vectors: addr, size, signed, store, be, lanes, load, flag
    localparam logic [104:0] VECS [NVEC] = '{
        {32'h0, 2'd0, 1'b1, 1'b0, 4'h0, 32'hB6B6B6B6, 32'h00000012, 1'b0},
        {32'h1, 2'd0, 1'b1, 1'b0, 4'h0, 32'hB6B6B6B6, 32'hFFFFFFF3, 1'b0},
        {32'h1, 2'd0, 1'b0, 1'b0, 4'h0, 32'hB6B6B6B6, 32'h000000F3, 1'b0},
        {32'h3, 2'd0, 1'b1, 1'b0, 4'h0, 32'hB6B6B6B6, 32'hFFFFFF8C, 1'b0},
        {32'h2, 2'd1, 1'b1, 1'b0, 4'h0, 32'hA5B6A5B6, 32'hFFFF8C7A, 1'b0},
        {32'h2, 2'd1, 1'b0, 1'b0, 4'h0, 32'hA5B6A5B6, 32'h00008C7A, 1'b0},
        {32'h0, 2'd1, 1'b1, 1'b0, 4'h0, 32'hA5B6A5B6, 32'hFFFFF312, 1'b0},
        {32'h0, 2'd2, 1'b1, 1'b0, 4'h0, 32'h1234A5B6, 32'h8C7AF312, 1'b0},
        {32'h2, 2'd2, 1'b0, 1'b0, 4'h0, 32'h1234A5B6, 32'h00000000, 1'b1},
        {32'h1, 2'd1, 1'b1, 1'b0, 4'h0, 32'hA5B6A5B6, 32'h00000000, 1'b1},
        {32'h2, 2'd0, 1'b0, 1'b1, 4'h4, 32'hB6B6B6B6, 32'h0000007A, 1'b0},
        {32'h2, 2'd1, 1'b0, 1'b1, 4'hC, 32'hA5B6A5B6, 32'h00008C7A, 1'b0},
        {32'h0, 2'd2, 1'b0, 1'b1, 4'hF, 32'h1234A5B6, 32'h8C7AF312, 1'b0},
        {32'h1, 2'd2, 1'b0, 1'b1, 4'h0, 32'h1234A5B6, 32'h00000000, 1'b1},
        {32'h3, 2'd1, 1'b0, 1'b1, 4'h0, 32'hA5B6A5B6, 32'h00000000, 1'b1},
        {32'h10000003, 2'd0, 1'b0, 1'b1, 4'h8, 32'hB6B6B6B6, 32'h0000008C, 1'b0},
        {32'h0, 2'd3, 1'b0, 1'b1, 4'hF, 32'h1234A5B6, 32'h8C7AF312, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic        is_signed = 1'b0;
    logic        is_store = 1'b0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  be_le, be_be;
    logic [31:0] sl_le, sl_be, ld_le, ld_be;
    logic        mis_le, mis_be;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ls_align #(.BIG_ENDIAN(1'b0)) u_ls_align (
        .addr(addr), .size(size), .is_signed(is_signed), .is_store(is_store),
        .store_data(store_data), .mem_rdata(mem_rdata),
        .byte_en(be_le), .store_lanes(sl_le), .load_data(ld_le),
        .misaligned(mis_le)
    );

    ls_align #(.BIG_ENDIAN(1'b1)) u_ls_align_be (
        .addr(addr), .size(size), .is_signed(is_signed), .is_store(is_store),
        .store_data(store_data), .mem_rdata(mem_rdata),
        .byte_en(be_be), .store_lanes(sl_be), .load_data(ld_be),
        .misaligned(mis_be)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [1:0] s,
                         input logic sg, input logic st);
        @(posedge clk);
        #1;
        addr = a; size = s; is_signed = sg; is_store = st;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state: zero inputs give a zero byte load and no enables.
        repeat (3) @(negedge clk);
        check("R4 reset byte_en", {28'h0, be_le}, 32'h0);
        check("R7 reset load", ld_le, 32'h0);
        check("R2 reset flag", {31'h0, mis_le}, 32'h0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        store_data = WDATA;
        mem_rdata  = RDATA;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            drive(v.addr, v.size, v.sgn, v.st);
            check(v.mis ? "R3 byte_en" : "R4 R8 byte_en", {28'h0, be_le}, {28'h0, v.be});
            check("R5 store_lanes", sl_le, v.wd);
            check(v.mis ? "R3 load" : (v.sgn ? "R6 R8 load" : "R7 R8 load"), ld_le, v.ld);
            check(v.size == 2'd1 ? "R2 flag" : "R1 flag", {31'h0, mis_le}, {31'h0, v.mis});
        end

        // Big-endian lane order.
        drive(32'h0, 2'd0, 1'b1, 1'b0);
        check("R8 R6 be byte off0", ld_be, 32'hFFFFFF8C);
        drive(32'h3, 2'd0, 1'b0, 1'b0);
        check("R8 R7 be byte off3", ld_be, 32'h00000012);
        drive(32'h0, 2'd1, 1'b0, 1'b0);
        check("R8 R7 be half off0", ld_be, 32'h00008C7A);
        drive(32'h2, 2'd1, 1'b1, 1'b0);
        check("R8 R6 be half off2", ld_be, 32'hFFFFF312);
        drive(32'h1, 2'd0, 1'b0, 1'b1);
        check("R8 be store byte off1", {28'h0, be_be}, 32'h4);
        drive(32'h0, 2'd1, 1'b0, 1'b1);
        check("R8 be store half off0", {28'h0, be_be}, 32'hC);
        drive(32'h0, 2'd2, 1'b0, 1'b0);
        check("R6 be word", ld_be, 32'h8C7AF312);
        drive(32'h6, 2'd2, 1'b0, 1'b1);
        check("R3 be misaligned en", {28'h0, be_be}, 32'h0);
        check("R1 be misaligned flag", {31'h0, mis_be}, 32'h1);

        // Same-cycle response: two offsets inside one clock period.
        @(posedge clk);
        #0.5;
        addr = 32'hFFFF_FFF0; size = 2'd0; is_signed = 1'b0; is_store = 1'b1;
        #0.5;
        check("R9 same cycle off0 en", {28'h0, be_le}, 32'h1);
        check("R9 same cycle off0 load", ld_le, 32'h00000012);
        addr = 32'hFFFF_FFF1;
        #0.5;
        check("R9 same cycle off1 en", {28'h0, be_le}, 32'h2);
        check("R9 same cycle off1 load", ld_le, 32'h000000F3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule